// File: doc/BRIEF.md
# Host-Side Reverse Byte Receiver with Run-Length Expansion

This block is the host end of the reverse channel of an enhanced bidirectional parallel port. A request gives a byte count. If the port is still driving forward, the block first turns the bus around. It then collects bytes from the peripheral with the reverse handshake. It tells data bytes from command bytes by the Busy level that is present when the byte is sampled. Run-length commands are expanded, so the consumer sees a plain stream of decompressed bytes on a valid/ready interface. A separate pulse hands the bus back to the forward direction. Any handshake that stalls past its limit ends the current phase, and an error pulse with a code reports it.

The controller is one state machine with these states:

| State | Role |
|---|---|
| `ST_FWD_IDLE` | Forward direction, idle. |
| `ST_TA_SETUP` | nAutoFd low, setup wait. |
| `ST_TA_WAIT` | nInit low, waits for PError low. |
| `ST_REV_IDLE` | Reverse direction, idle. |
| `ST_DISPATCH` | Picks the next action. |
| `ST_WAIT_BYTE` | Waits for nAck low. |
| `ST_EMIT` | Presents a bus data byte. |
| `ST_REPEAT` | Presents the stored repeat byte with no bus activity. |
| `ST_ACK_HI` | nAutoFd high, waits for nAck high. |
| `ST_TF_WAIT` | nInit high, waits for PError high. |

Transitions:
- FWD_IDLE to TA_SETUP on a request.
- TA_SETUP to TA_WAIT after the setup time.
- TA_WAIT to DISPATCH when PError is low, or back to FWD_IDLE on timeout.
- REV_IDLE to DISPATCH on a request, or to TF_WAIT on a turn-forward pulse.
- DISPATCH goes to REV_IDLE when the count is exhausted, to REPEAT when repeats are pending, and to WAIT_BYTE otherwise.
- WAIT_BYTE goes to EMIT for a data byte, to ACK_HI for a command byte, and to REV_IDLE on idle timeout.
- EMIT goes to ACK_HI once the byte is accepted.
- REPEAT goes back to DISPATCH when the run or the count is used up.
- ACK_HI goes to DISPATCH when nAck rises, or to REV_IDLE on timeout.
- TF_WAIT goes to FWD_IDLE when PError rises or on timeout.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the block is in forward idle. nStrobe, nAutoFd, nInit and nSelectIn are all high, `dir_rev` is low, `idle` is high and `out_valid` is low.
- R2: A request in forward idle holds nAutoFd low for exactly SETUP_CYC cycles with nInit high. nInit then goes low while nStrobe and nSelectIn stay high and `dir_rev` goes high. The byte phase starts once PError is low.
- R3: If PError stays high for RESP_CYC cycles after nInit falls, the block pulses `err_valid` with `err_code` 0. It then returns to forward idle with all four control lines high and `dir_rev` low.
- R4: When nAck is low and Busy is high, the byte on `bus_data` is a data byte and appears on `out_data` with `out_valid`.
- R5: After a byte is taken, nAutoFd rises until nAck is seen high, then falls again. If nAck stays low for RESP_CYC cycles, `err_valid` pulses with `err_code` 2 and the block enters reverse idle.
- R6: If nAck stays high for IDLE_CYC cycles while a byte is awaited, `err_valid` pulses with `err_code` 1 and the request ends in reverse idle.
- R7: A byte taken with Busy low and bit 7 clear is a run count N and produces no output. The next data byte is output once and stored. The stored byte is then output N more times with no bus handshake, capped by the bytes still owed to the request.
- R8: A byte taken with Busy low and bit 7 set is acknowledged on the bus and produces no output.
- R9: Repeats left over when a request's count runs out are kept. A later request outputs them first, with no nAutoFd pulse.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds and nAutoFd stays low, so the peripheral is not acknowledged.
- R11: A request outputs exactly `req_count` bytes and then returns to idle. A count of zero returns to idle with no output.
- R12: A `turn_fwd` pulse in reverse idle raises nInit. When PError is high, nAutoFd rises, `dir_rev` falls and the block is in forward idle, with any pending repeats discarded. If PError stays low for RESP_CYC cycles, the same end state is reached with `err_code` 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start a request; taken only when `idle` is high |
| req_count | input | CNT_W | Number of bytes the request delivers |
| turn_fwd | input | 1 | Hand the bus back to forward; taken in reverse idle |
| bus_data | input | 8 | Parallel data lines driven by the peripheral |
| st_nack | input | 1 | Synchronized nAck status line |
| st_busy | input | 1 | Synchronized Busy status line |
| st_perror | input | 1 | Synchronized PError status line |
| ctl_nstrobe | output | 1 | nStrobe control line |
| ctl_nautofd | output | 1 | nAutoFd control line |
| ctl_ninit | output | 1 | nInit control line |
| ctl_nselectin | output | 1 | nSelectIn control line |
| dir_rev | output | 1 | High while the peripheral owns the data lines |
| idle | output | 1 | High in forward idle or reverse idle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| err_valid | output | 1 | One-cycle timeout pulse |
| err_code | output | 2 | 0 turn-to-reverse, 1 idle wait, 2 byte acknowledge, 3 turn-to-forward |

## Verification
The bench builds the block with CNT_W=8, SETUP_CYC=3, RESP_CYC=8 and IDLE_CYC=40. These small limits put all four timeout paths within a few dozen cycles, so each error code is driven and checked. With the short setup time, the nAutoFd-to-nInit spacing can be counted exactly. An 8-bit count keeps the requests short, which leaves room for runs that cross request boundaries and for back-pressure that toggles or holds.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

    typedef enum logic [3:0] {
        ST_FWD_IDLE,
        ST_TA_SETUP,
        ST_TA_WAIT,
        ST_REV_IDLE,
        ST_DISPATCH,
        ST_WAIT_BYTE,
        ST_EMIT,
        ST_REPEAT,
        ST_ACK_HI,
        ST_TF_WAIT
    } rx_state_e;

    typedef enum logic [1:0] {
        ERR_TURN_REV = 2'd0,
        ERR_IDLE     = 2'd1,
        ERR_ACK      = 2'd2,
        ERR_TURN_FWD = 2'd3
    } rx_err_e;

    // run-length count field of a command byte
    localparam int RUN_W = 7;

endpackage

// File: rtl/ecp_rx_timer.sv
module ecp_rx_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // cycles spent in the current state, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/ecp_rx_rle.sv
module ecp_rx_rle
    import ecp_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic [RUN_W-1:0] arm_cnt,
    input  logic             capture,
    input  logic [7:0]       cap_byte,
    input  logic             consume,
    output logic             run_pending,
    output logic             run_last,
    output logic [7:0]       rep_byte
);

    logic [RUN_W-1:0] cnt_q;
    logic             flag_q;
    logic [7:0]       byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
            byte_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (arm) begin
            cnt_q  <= arm_cnt;
            flag_q <= 1'b1;
        end else if (capture && flag_q) begin
            byte_q <= cap_byte;
            flag_q <= 1'b0;
        end else if (consume) begin
            cnt_q <= cnt_q - RUN_W'(1);
        end
    end

    assign run_pending = (cnt_q != '0) && !flag_q;
    assign run_last    = (cnt_q == RUN_W'(1));
    assign rep_byte    = byte_q;

    AST_RUN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (cnt_q != '0) && !flag_q); // R7

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecp_rx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SETUP_CYC = 25,
    parameter int RESP_CYC  = 150,
    parameter int IDLE_CYC  = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             turn_fwd,
    input  logic [7:0]       bus_data,
    input  logic             st_nack,
    input  logic             st_busy,
    input  logic             st_perror,
    output logic             ctl_nstrobe,
    output logic             ctl_nautofd,
    output logic             ctl_ninit,
    output logic             ctl_nselectin,
    output logic             dir_rev,
    output logic             idle,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             err_valid,
    output logic [1:0]       err_code
);

    localparam int LIM_A   = (SETUP_CYC > RESP_CYC) ? SETUP_CYC : RESP_CYC;
    localparam int MAX_LIM = (LIM_A > IDLE_CYC) ? LIM_A : IDLE_CYC;
    localparam int TMR_W   = $clog2(MAX_LIM + 1);
    localparam logic [TMR_W-1:0] SETUP_LAST = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] RESP_LAST  = TMR_W'(RESP_CYC - 1);
    localparam logic [TMR_W-1:0] IDLE_LAST  = TMR_W'(IDLE_CYC - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       byte_q;
    logic [TMR_W-1:0] tcnt;
    logic             rle_arm, rle_cap, rle_use, rle_clr;
    logic             run_pending, run_last;
    logic [7:0]       rep_byte;
    logic             tmo;
    rx_err_e          tmo_code;

    ecp_rx_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (tcnt)
    );

    ecp_rx_rle u_rle (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (rle_clr),
        .arm         (rle_arm),
        .arm_cnt     (bus_data[RUN_W-1:0]),
        .capture     (rle_cap),
        .cap_byte    (byte_q),
        .consume     (rle_use),
        .run_pending (run_pending),
        .run_last    (run_last),
        .rep_byte    (rep_byte)
    );

    assign rle_clr = (state_d == ST_FWD_IDLE) && (state_q != ST_FWD_IDLE);

    // next state and datapath strobes
    always_comb begin
        state_d  = state_q;
        rle_arm  = 1'b0;
        rle_cap  = 1'b0;
        rle_use  = 1'b0;
        tmo      = 1'b0;
        tmo_code = ERR_IDLE;
        unique case (state_q)
            ST_FWD_IDLE: if (req_start) state_d = ST_TA_SETUP;
            ST_TA_SETUP: if (tcnt == SETUP_LAST) state_d = ST_TA_WAIT;
            ST_TA_WAIT: begin
                if (!st_perror) begin
                    state_d = ST_DISPATCH;
                end else if (tcnt == RESP_LAST) begin
                    state_d  = ST_FWD_IDLE;
                    tmo      = 1'b1;
                    tmo_code = ERR_TURN_REV;
                end
            end
            ST_REV_IDLE: begin
                if (req_start)     state_d = ST_DISPATCH;
                else if (turn_fwd) state_d = ST_TF_WAIT;
            end
            ST_DISPATCH: begin
                if (rem_q == '0)      state_d = ST_REV_IDLE;
                else if (run_pending) state_d = ST_REPEAT;
                else                  state_d = ST_WAIT_BYTE;
            end
            ST_WAIT_BYTE: begin
                if (!st_nack) begin
                    if (st_busy) begin
                        state_d = ST_EMIT;
                    end else begin
                        rle_arm = !bus_data[7];
                        state_d = ST_ACK_HI;
                    end
                end else if (tcnt == IDLE_LAST) begin
                    state_d  = ST_REV_IDLE;
                    tmo      = 1'b1;
                    tmo_code = ERR_IDLE;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    rle_cap = 1'b1;
                    state_d = ST_ACK_HI;
                end
            end
            ST_REPEAT: begin
                if (out_ready) begin
                    rle_use = 1'b1;
                    if (run_last || rem_q == CNT_W'(1)) state_d = ST_DISPATCH;
                end
            end
            ST_ACK_HI: begin
                if (st_nack) begin
                    state_d = ST_DISPATCH;
                end else if (tcnt == RESP_LAST) begin
                    state_d  = ST_REV_IDLE;
                    tmo      = 1'b1;
                    tmo_code = ERR_ACK;
                end
            end
            ST_TF_WAIT: begin
                if (st_perror) begin
                    state_d = ST_FWD_IDLE;
                end else if (tcnt == RESP_LAST) begin
                    state_d  = ST_FWD_IDLE;
                    tmo      = 1'b1;
                    tmo_code = ERR_TURN_FWD;
                end
            end
            default: state_d = ST_FWD_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FWD_IDLE;
            rem_q     <= '0;
            byte_q    <= '0;
            err_valid <= 1'b0;
            err_code  <= 2'd0;
        end else begin
            state_q   <= state_d;
            err_valid <= tmo;
            if (tmo) err_code <= tmo_code;
            if (req_start && (state_q == ST_FWD_IDLE || state_q == ST_REV_IDLE)) begin
                rem_q <= req_count;
            end else if (out_valid && out_ready) begin
                rem_q <= rem_q - CNT_W'(1);
            end
            if (state_q == ST_WAIT_BYTE && !st_nack) byte_q <= bus_data;
        end
    end

    // Moore outputs
    always_comb begin
        ctl_nstrobe   = 1'b1;
        ctl_nselectin = 1'b1;
        ctl_nautofd   = 1'b0;
        ctl_ninit     = 1'b0;
        dir_rev       = 1'b1;
        idle          = 1'b0;
        out_valid     = 1'b0;
        out_data      = byte_q;
        unique case (state_q)
            ST_FWD_IDLE: begin
                ctl_nautofd = 1'b1;
                ctl_ninit   = 1'b1;
                dir_rev     = 1'b0;
                idle        = 1'b1;
            end
            ST_TA_SETUP: begin
                ctl_ninit = 1'b1;
                dir_rev   = 1'b0;
            end
            ST_REV_IDLE: idle = 1'b1;
            ST_EMIT:     out_valid = 1'b1;
            ST_REPEAT: begin
                out_valid = 1'b1;
                out_data  = rep_byte;
            end
            ST_ACK_HI:  ctl_nautofd = 1'b1;
            ST_TF_WAIT: ctl_ninit = 1'b1;
            default: ;
        endcase
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
    AST_NO_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ctl_nautofd); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rem_q != '0); // R11
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> idle); // R6
    AST_TURN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_ninit) |-> !ctl_nautofd); // R2

endmodule

// File: tb/ecp_rev_rx_test.sv
`timescale 1ns/1ps
module ecp_rev_rx_test;

    localparam int SETUP = 3;
    localparam int RESP  = 8;
    localparam int IDLEL = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic [7:0] req_count = '0;
    logic       turn_fwd = 1'b0;
    logic [7:0] bus_data = '0;
    logic       st_nack = 1'b1;
    logic       st_busy = 1'b1;
    logic       st_perror = 1'b1;
    logic       out_ready = 1'b1;
    logic       ctl_nstrobe, ctl_nautofd, ctl_ninit, ctl_nselectin;
    logic       dir_rev, idle, out_valid, err_valid;
    logic [7:0] out_data;
    logic [1:0] err_code;

    int    n_chk = 0;
    int    n_err = 0;
    int    err_seen = 0;
    int    err_last = -1;
    int    ack_rises = 0;
    int    bp_mode = 0;
    int    rdy_phase = 0;
    logic  prev_af = 1'b1;
    logic  done = 1'b0;
    string cur_req = "R1";
    logic [7:0] exp_q[$];
    logic [7:0] e;

    always #2 clk = ~clk;

    ecp_rev_rx #(.CNT_W(8), .SETUP_CYC(SETUP), .RESP_CYC(RESP), .IDLE_CYC(IDLEL)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_count(req_count),
        .turn_fwd(turn_fwd), .bus_data(bus_data), .st_nack(st_nack), .st_busy(st_busy),
        .st_perror(st_perror), .ctl_nstrobe(ctl_nstrobe), .ctl_nautofd(ctl_nautofd),
        .ctl_ninit(ctl_ninit), .ctl_nselectin(ctl_nselectin), .dir_rev(dir_rev),
        .idle(idle), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // consumer ready, changes just after the rising edge
    always @(posedge clk) begin
        #1;
        rdy_phase++;
        case (bp_mode)
            1:       out_ready = (rdy_phase % 3) != 0;
            2:       out_ready = 1'b0;
            default: out_ready = 1'b1;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected byte"}, out_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_data == e, cur_req, out_data, e);
                end
            end
            if (err_valid) begin
                err_seen++;
                err_last = err_code;
            end
            if (ctl_nautofd && !prev_af) ack_rises++;
            prev_af = ctl_nautofd;
        end
    end

    task automatic push(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(b);
    endtask

    task automatic do_req(input int n);
        @(negedge clk);
        req_count = 8'(n);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600 && !idle; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic perif_turn_rev();
        for (int i = 0; i < 60 && ctl_ninit; i++) @(negedge clk);
        @(negedge clk);
        st_perror = 1'b0;
    endtask

    task automatic send(input logic busy, input logic [7:0] d);
        @(negedge clk);
        bus_data = d;
        st_busy  = busy;
        st_nack  = 1'b0;
        for (int i = 0; i < 300 && !ctl_nautofd; i++) @(negedge clk);
        st_nack = 1'b1;
        for (int i = 0; i < 60 && ctl_nautofd; i++) @(negedge clk);
    endtask

    task automatic turn_forward(input bit respond);
        @(negedge clk);
        turn_fwd = 1'b1;
        @(negedge clk);
        turn_fwd = 1'b0;
        if (respond) begin
            for (int i = 0; i < 60 && !ctl_ninit; i++) @(negedge clk);
            st_perror = 1'b1;
        end
        wait_idle();
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int base;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_nstrobe && ctl_nautofd && ctl_ninit && ctl_nselectin, "R1 control lines",
            {ctl_nstrobe, ctl_nautofd, ctl_ninit, ctl_nselectin}, 4'hf);
        chk(!dir_rev && idle && !out_valid, "R1 dir/idle/valid", {dir_rev, idle, out_valid}, 3'b010);

        // R3 turnaround timeout
        cur_req = "R3";
        base = err_seen;
        do_req(1);
        wait_idle();
        chk(err_seen == base + 1 && err_last == 0, "R3 err code", err_last, 0);
        chk(ctl_nautofd && ctl_ninit && !dir_rev && idle, "R3 back to forward",
            {ctl_nautofd, ctl_ninit, dir_rev, idle}, 4'b1101);

        // R2 turnaround, R4/R5/R11 plain data bytes
        cur_req = "R4";
        push(8'hA1, 1); push(8'hB2, 1); push(8'hC3, 1); push(8'hD4, 1);
        do_req(4);
        cnt = 0;
        for (int i = 0; i < 60 && ctl_ninit; i++) begin
            if (!ctl_nautofd) cnt++;
            @(negedge clk);
        end
        chk(cnt == SETUP, "R2 setup cycles", cnt, SETUP);
        chk(!ctl_ninit && ctl_nstrobe && ctl_nselectin && dir_rev && !ctl_nautofd, "R2 reverse lines",
            {ctl_ninit, ctl_nstrobe, ctl_nselectin, dir_rev, ctl_nautofd}, 5'b01110);
        perif_turn_rev();
        base = ack_rises;
        send(1'b1, 8'hA1); send(1'b1, 8'hB2); send(1'b1, 8'hC3); send(1'b1, 8'hD4);
        wait_idle();
        chk(ack_rises - base == 4, "R5 one nAutoFd pulse per byte", ack_rises - base, 4);
        chk(exp_q.size() == 0 && idle && dir_rev, "R11 count delivered", exp_q.size(), 0);

        // R7 run-length expansion
        cur_req = "R7";
        push(8'h5A, 4); push(8'h11, 1); push(8'h22, 1);
        do_req(6);
        send(1'b0, 8'h03); send(1'b1, 8'h5A); send(1'b1, 8'h11); send(1'b1, 8'h22);
        wait_idle();
        chk(exp_q.size() == 0, "R7 stream complete", exp_q.size(), 0);

        // R8 channel byte dropped, R7 run capped by request
        cur_req = "R8";
        push(8'h77, 5);
        do_req(5);
        send(1'b0, 8'h85); send(1'b0, 8'h07); send(1'b1, 8'h77);
        wait_idle();
        chk(exp_q.size() == 0, "R8 no output from channel byte", exp_q.size(), 0);

        // R9 leftover repeats drained without bus handshake
        cur_req = "R9";
        push(8'h77, 2);
        base = ack_rises;
        do_req(2);
        wait_idle();
        chk(exp_q.size() == 0, "R9 leftover drained", exp_q.size(), 0);
        chk(ack_rises == base, "R9 no bus acknowledge", ack_rises - base, 0);

        // R10 toggling back-pressure
        cur_req = "R10";
        bp_mode = 1;
        push(8'h77, 1); push(8'h99, 1); push(8'h98, 1);
        do_req(3);
        send(1'b1, 8'h99); send(1'b1, 8'h98);
        wait_idle();
        chk(exp_q.size() == 0, "R10 stream under back-pressure", exp_q.size(), 0);

        // R10 hold while not ready
        bp_mode = 2;
        do_req(1);
        @(negedge clk);
        bus_data = 8'h42; st_busy = 1'b1; st_nack = 1'b0;
        repeat (12) @(negedge clk);
        chk(out_valid && out_data == 8'h42, "R10 byte held", out_data, 8'h42);
        chk(!ctl_nautofd, "R10 no acknowledge while stalled", ctl_nautofd, 0);
        push(8'h42, 1);
        bp_mode = 0;
        for (int i = 0; i < 60 && !ctl_nautofd; i++) @(negedge clk);
        st_nack = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R10 byte released", exp_q.size(), 0);

        // R11 zero count
        cur_req = "R11";
        base = ack_rises;
        do_req(0);
        wait_idle();
        chk(idle && ack_rises == base, "R11 zero count", idle, 1);

        // R5 acknowledge timeout
        cur_req = "R5";
        base = err_seen;
        push(8'h10, 1);
        do_req(1);
        @(negedge clk);
        bus_data = 8'h10; st_busy = 1'b1; st_nack = 1'b0;
        wait_idle();
        chk(err_seen == base + 1 && err_last == 2, "R5 err code", err_last, 2);
        chk(!ctl_nautofd && dir_rev, "R5 reverse idle lines", ctl_nautofd, 0);
        st_nack = 1'b1;
        @(negedge clk);

        // R6 idle timeout
        cur_req = "R6";
        base = err_seen;
        do_req(2);
        wait_idle();
        chk(err_seen == base + 1 && err_last == 1, "R6 err code", err_last, 1);
        chk(idle && dir_rev, "R6 reverse idle", idle, 1);

        // R12 turn forward discards pending run
        cur_req = "R12";
        push(8'h33, 1);
        do_req(1);
        send(1'b0, 8'h05); send(1'b1, 8'h33);
        wait_idle();
        base = err_seen;
        turn_forward(1'b1);
        chk(ctl_nautofd && ctl_ninit && !dir_rev && idle && err_seen == base, "R12 forward idle",
            {ctl_nautofd, ctl_ninit, dir_rev, idle}, 4'b1101);
        push(8'h44, 1); push(8'h45, 1);
        do_req(2);
        perif_turn_rev();
        send(1'b1, 8'h44); send(1'b1, 8'h45);
        wait_idle();
        chk(exp_q.size() == 0, "R12 pending run discarded", exp_q.size(), 0);
        turn_forward(1'b0);
        chk(err_seen == base + 1 && err_last == 3, "R12 err code", err_last, 3);
        chk(!dir_rev && ctl_nautofd && idle, "R12 forward after timeout", dir_rev, 0);

        report();
        done = 1'b1;
        $finish;
    end

endmodule